// File: doc/BRIEF.md
# Write Guard and Program-Cycle Timer

This block sits between the serial bus front end of a small 256-byte non-volatile store and its array. When the front end sees a STOP that closes a write, it hands over one request: the start address, how many data bytes were gathered, and whether the control code aimed at the lock register instead of the array. The block starts a fixed busy window, which models the self-timed programming cycle. During that window it tells the front end to withhold every acknowledge. It also sends out one commit pulse per gathered byte, with the array address and the page-buffer slot that byte came from.

Two protection sources filter those commits. A software lock can only be set, by a request aimed at the lock register, and only a block reset clears it. While it is set, no byte whose address has the top bit clear (the lower half, 00h to 7Fh) is committed. A hardware protect input, sampled at the STOP, stops every commit whatever the lock says. A write that is filtered out still costs the whole busy window. The front end acknowledges it as usual.

Top module: `wcg_guard`

## Requirements
- R1: After reset, `busy`, `ack_block`, `commit_en` and `sw_lock` are all 0.
- R2: A request accepted while idle (`stop_req`=1 with `busy`=0) raises `busy` on the next cycle. `busy` then stays high for exactly WCYC cycles.
- R3: `ack_block` is high in exactly the cycles where `busy` is high.
- R4: A `stop_req` that arrives while `busy` is high is ignored. It does not lengthen the busy window, it adds no commits and it does not change `sw_lock`.
- R5: With no protection active, an array request of N bytes (1 ≤ N ≤ 16) gives `commit_en` in busy cycles 1 to N and never after. In cycle k, `commit_slot` is k−1.
- R6: The address of commit k keeps the request's upper four address bits. Its lower four bits are the start's lower four bits plus k−1, modulo 16, so a page wraps onto itself.
- R7: A request with `req_reg`=1 sets `sw_lock` on the cycle after acceptance. It commits nothing and still runs the full busy window.
- R8: Once `sw_lock` is 1, it stays 1 until reset, including across further lock requests.
- R9: While `sw_lock` is 1, bytes with address bit 7 equal to 0 are never committed. Bytes with bit 7 equal to 1 are still committed.
- R10: If `hw_wp` is 1 in the accept cycle, the request commits nothing but still runs the full busy window.
- R11: A byte count above 16 is treated as 16. A count of 0 commits nothing but still runs the busy window.
- R12: Changes of `hw_wp` during a busy window do not change which bytes of that request are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also the power-on clear of the lock |
| hw_wp | input | 1 | Hardware protect for the whole array, sampled at acceptance |
| stop_req | input | 1 | One-cycle pulse: the front end saw a STOP closing a write |
| req_addr | input | 8 | Start address of the write |
| req_cnt | input | 6 | Number of data bytes gathered |
| req_reg | input | 1 | 1 when the request targets the lock register |
| busy | output | 1 | Programming window in progress |
| ack_block | output | 1 | Front end must not acknowledge |
| commit_en | output | 1 | Commit one byte to the array this cycle |
| commit_addr | output | 8 | Array address of the byte being committed |
| commit_slot | output | 4 | Page-buffer slot that holds that byte |
| sw_lock | output | 1 | Software lock of the lower half |

## Verification
The hardest case to reach is a second STOP that lands inside a running busy window and carries a lock request. If it were wrongly accepted, it would both stretch the window and set the lock. The stimulus starts a short array write and then, a few cycles into the window, pulses `stop_req` with `req_reg` high. It then checks that `busy` still drops on the expected cycle and that `sw_lock` stays clear. A second hard case is flipping `hw_wp` partway through a window. This is reached by toggling the input between sampled cycles of a running page write. The bench confirms that every byte of that request is still committed.

// File: rtl/wcg_pkg.sv
package wcg_pkg;
   typedef enum logic {
      WCG_IDLE = 1'b0,
      WCG_BUSY = 1'b1
   } wcg_phase_e;
endpackage

// File: rtl/wcg_lock.sv
module wcg_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   output logic lock_o
);
   // set-only: the only way back to 0 is the reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lock_o <= 1'b0;
      else if (set_i) lock_o <= 1'b1;
   end
endmodule

// File: rtl/wcg_timer.sv
module wcg_timer #(
   parameter int WCYC = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   import wcg_pkg::*;
   localparam int CNT_W = $clog2(WCYC + 1);

   wcg_phase_e       phase_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= WCG_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            WCG_IDLE: if (start_i) begin
               phase_q <= WCG_BUSY;
               cnt_q   <= CNT_W'(1);
            end
            WCG_BUSY: if (cnt_q == CNT_W'(WCYC)) begin
               phase_q <= WCG_IDLE;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
            default: phase_q <= WCG_IDLE;
         endcase
      end
   end

   assign busy_o = (phase_q == WCG_BUSY);
endmodule

// File: rtl/wcg_walker.sv
module wcg_walker #(
   parameter int ADDR_W     = 8,
   parameter int PAGE_W     = 4,
   parameter bit PROT_LOWER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [PAGE_W:0]   nbytes_i,
   input  logic              hw_blk_i,
   input  logic              sw_blk_i,
   output logic              commit_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [PAGE_W-1:0] slot_o
);
   localparam int LEN_W = PAGE_W + 1;

   logic              active_q, hw_q, sw_q;
   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  len_q, idx_q;
   logic              in_zone, allowed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         hw_q     <= 1'b0;
         sw_q     <= 1'b0;
         base_q   <= '0;
         len_q    <= '0;
         idx_q    <= '0;
      end else if (start_i) begin
         active_q <= (nbytes_i != '0);
         hw_q     <= hw_blk_i;
         sw_q     <= sw_blk_i;
         base_q   <= base_i;
         len_q    <= nbytes_i;
         idx_q    <= '0;
      end else if (active_q) begin
         if (idx_q == len_q - LEN_W'(1)) active_q <= 1'b0;
         idx_q <= idx_q + LEN_W'(1);
      end
   end

   // page-local increment: the upper part of the address never moves
   assign addr_o = {base_q[ADDR_W-1:PAGE_W], base_q[PAGE_W-1:0] + idx_q[PAGE_W-1:0]};
   assign slot_o = idx_q[PAGE_W-1:0];

   generate
      if (PROT_LOWER) begin : g_zone_lo
         assign in_zone = ~addr_o[ADDR_W-1];
      end else begin : g_zone_hi
         assign in_zone = addr_o[ADDR_W-1];
      end
   endgenerate

   assign allowed  = ~hw_q & ~(sw_q & in_zone);
   assign commit_o = active_q & allowed;
endmodule

// File: rtl/wcg_guard.sv
module wcg_guard #(
   parameter int ADDR_W     = 8,
   parameter int PAGE_W     = 4,
   parameter int WCYC       = 2000,
   parameter bit PROT_LOWER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_wp,
   input  logic              stop_req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [PAGE_W+1:0] req_cnt,
   input  logic              req_reg,
   output logic              busy,
   output logic              ack_block,
   output logic              commit_en,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [PAGE_W-1:0] commit_slot,
   output logic              sw_lock
);
   localparam int PAGE  = 2 ** PAGE_W;
   localparam int LEN_W = PAGE_W + 1;
   localparam int REQ_W = PAGE_W + 2;

   generate
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("wcg_guard: PAGE_W must lie in 1..ADDR_W-1");
      end
      if (WCYC < PAGE) begin : g_bad_wcyc
         $error("wcg_guard: WCYC must cover a whole page of commits");
      end
   endgenerate

   logic             accept;
   logic [LEN_W-1:0] nbytes;

   assign accept = stop_req & ~busy;
   assign nbytes = (req_cnt > REQ_W'(PAGE)) ? LEN_W'(PAGE) : req_cnt[LEN_W-1:0];

   wcg_lock u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (accept & req_reg),
      .lock_o (sw_lock)
   );

   wcg_timer #(.WCYC(WCYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept),
      .busy_o  (busy)
   );

   wcg_walker #(
      .ADDR_W     (ADDR_W),
      .PAGE_W     (PAGE_W),
      .PROT_LOWER (PROT_LOWER)
   ) u_walker (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (accept & ~req_reg),
      .base_i   (req_addr),
      .nbytes_i (nbytes),
      .hw_blk_i (hw_wp),
      .sw_blk_i (sw_lock),
      .commit_o (commit_en),
      .addr_o   (commit_addr),
      .slot_o   (commit_slot)
   );

   assign ack_block = busy;
endmodule

// File: rtl/wcg_guard_chk.sv
module wcg_guard_chk #(
   parameter int ADDR_W = 8,
   parameter int WCYC   = 2000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hw_wp,
   input logic              stop_req,
   input logic              req_reg,
   input logic              busy,
   input logic              ack_block,
   input logic              commit_en,
   input logic [ADDR_W-1:0] commit_addr,
   input logic              sw_lock
);
   localparam int RUN_W = $clog2(WCYC + 1);
   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + RUN_W'(1);
      else           run_q <= '0;
   end

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !busy) |=> busy);
   p_window_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < RUN_W'(WCYC)));
   p_ack_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ack_block == busy);
   p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_req));
   p_commit_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_en |-> busy);
   p_lock_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !busy && req_reg) |=> sw_lock);
   p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_lock |=> sw_lock);
   p_lower_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_en && sw_lock) |-> commit_addr[ADDR_W-1]);
   p_hw_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !busy && hw_wp) |=> !commit_en);
endmodule

bind wcg_guard wcg_guard_chk #(.ADDR_W(ADDR_W), .WCYC(WCYC)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .hw_wp       (hw_wp),
   .stop_req    (stop_req),
   .req_reg     (req_reg),
   .busy        (busy),
   .ack_block   (ack_block),
   .commit_en   (commit_en),
   .commit_addr (commit_addr),
   .sw_lock     (sw_lock)
);

// File: tb/wcg_guard_tb_top.sv
module wcg_guard_tb_top;
   localparam int WCYC = 40;
   localparam int NVEC = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_wp = 1'b0;
   logic       stop_req = 1'b0;
   logic [7:0] req_addr = '0;
   logic [5:0] req_cnt = '0;
   logic       req_reg = 1'b0;
   logic       busy, ack_block, commit_en, sw_lock;
   logic [7:0] commit_addr;
   logic [3:0] commit_slot;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   wcg_guard #(.WCYC(WCYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .hw_wp(hw_wp), .stop_req(stop_req),
      .req_addr(req_addr), .req_cnt(req_cnt), .req_reg(req_reg),
      .busy(busy), .ack_block(ack_block), .commit_en(commit_en),
      .commit_addr(commit_addr), .commit_slot(commit_slot), .sw_lock(sw_lock)
   );

   // {addr, count, reg, hw, expected commits, expected lock afterwards}
   localparam logic [21:0] VEC [NVEC] = '{
      {8'h10, 6'd1,  1'b0, 1'b0, 5'd1,  1'b0},  // R5 single byte
      {8'h3C, 6'd8,  1'b0, 1'b0, 5'd8,  1'b0},  // R6 wrap in page
      {8'h90, 6'd16, 1'b0, 1'b0, 5'd16, 1'b0},  // R5 full page
      {8'h20, 6'd4,  1'b0, 1'b1, 5'd0,  1'b0},  // R10 hw protect
      {8'hA5, 6'd20, 1'b0, 1'b0, 5'd16, 1'b0},  // R11 clamp
      {8'h50, 6'd0,  1'b0, 1'b0, 5'd0,  1'b0},  // R11 zero count
      {8'h00, 6'd0,  1'b1, 1'b0, 5'd0,  1'b1},  // R7 set lock
      {8'h40, 6'd3,  1'b0, 1'b0, 5'd0,  1'b1},  // R9 lower blocked
      {8'hC8, 6'd5,  1'b0, 1'b0, 5'd5,  1'b1},  // R9 upper allowed
      {8'hF0, 6'd2,  1'b0, 1'b1, 5'd0,  1'b1},  // R10 hw over lock
      {8'h00, 6'd0,  1'b1, 1'b0, 5'd0,  1'b1},  // R8 second lock request
      {8'h7F, 6'd2,  1'b0, 1'b0, 5'd0,  1'b1}   // R9 lower wrap blocked
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // issue one request and watch the whole window that follows
   task automatic run_req(input logic [7:0] a, input logic [5:0] n, input logic rg,
                          input logic hw, input int exp_n, input bit flip_hw,
                          input bit inject);
      logic [7:0] ea;
      @(negedge clk);
      req_addr = a; req_cnt = n; req_reg = rg; hw_wp = hw; stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      for (int c = 1; c <= WCYC + 1; c++) begin
         if (c > 1) @(negedge clk);
         ea = {a[7:4], 4'(a[3:0] + 4'(c - 1))};
         check(busy == (c <= WCYC), "R2 busy window", busy, c <= WCYC);
         check(ack_block == busy, "R3 ack_block", ack_block, busy);
         check(commit_en == (c <= exp_n), "R5 commit pulse", commit_en, c <= exp_n);
         if (c <= exp_n) begin
            check(commit_addr == ea, "R6 commit address", commit_addr, ea);
            check(commit_slot == 4'(c - 1), "R5 commit slot", commit_slot, c - 1);
         end
         if (flip_hw && c == 3) hw_wp = ~hw_wp;                      // R12
         if (inject && c == 5) begin stop_req = 1'b1; req_reg = 1'b1; end  // R4
         if (inject && c == 6) begin stop_req = 1'b0; req_reg = 1'b0; end
      end
      hw_wp = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      check(!busy && !ack_block && !commit_en && !sw_lock, "R1 reset state",
            {busy, ack_block, commit_en, sw_lock}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !sw_lock, "R1 idle after reset", {busy, sw_lock}, 0);

      // R4: a lock request during the window must be ignored
      run_req(8'h12, 6'd2, 1'b0, 1'b0, 2, 1'b0, 1'b1);
      check(sw_lock == 1'b0, "R4 lock unchanged", sw_lock, 0);

      foreach (VEC[i]) begin
         run_req(VEC[i][21:14], VEC[i][13:8], VEC[i][7], VEC[i][6],
                 int'(VEC[i][5:1]), 1'b0, 1'b0);
         check(sw_lock == VEC[i][0], "R7 R8 lock state", sw_lock, VEC[i][0]);
      end

      // R12: hw protect raised mid-window keeps commits of an upper page
      run_req(8'h80, 6'd6, 1'b0, 1'b0, 6, 1'b1, 1'b0);
      // R12: hw protect dropped mid-window keeps the request blocked
      run_req(8'hE0, 6'd6, 1'b0, 1'b1, 0, 1'b1, 1'b0);

      // R8: only reset clears the lock, after which the lower half is writable
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(sw_lock == 1'b0, "R8 lock cleared by reset", sw_lock, 0);
      rst_n = 1'b1;
      run_req(8'h20, 6'd1, 1'b0, 1'b0, 1, 1'b0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule